// File: doc/BRIEF.md
# Reconfigurable Weak Edge Smoother

This block smooths one line of pixels that straddles a block boundary in a decoded picture. Each input line carries eight 8-bit pixels, four on each side of the edge. A per-line mode bit picks between two behaviours. In-loop mode follows the normal-strength deblocking rule of H.264/AVC. Post-loop mode applies a softer correction that suits MPEG-2 output. Only the two pixels next to the edge are ever changed. Boundary strength, the clip bound and the activity thresholds come from upstream logic on every line.

Both modes use one datapath. The only part that differs is the arithmetic that forms the raw correction. After that, a shared stage clamps the correction to a bound, adds it to the near pixel on one side, subtracts it from the near pixel on the other side, and saturates both results to the pixel range. A decision unit checks whether the edge should be touched at all, and its verdict selects between the corrected pixels and the raw pixels. The block accepts a new line on every cycle and returns each line exactly two cycles later, with its valid flag travelling alongside.

Top module: `edge_smoother`

## Requirements
- R1: A line presented with `in_vld` high at a rising edge appears on `pix_out` with `out_vld` high exactly two rising edges later. Lane k sits at bits [8k+7:8k]. Lanes 0..3 hold the pixels on the first side, from the far pixel (lane 0) to the pixel next to the edge (lane 3, called P0). Lanes 4..7 hold the second side, from the pixel next to the edge (lane 4, called Q0) to the far pixel (lane 7). Lanes 2 and 5 are called P1 and Q1.
- R2: While `rst_n` is low, `out_vld` is 0 and `pix_out` is all zeros.
- R3: Lanes 0, 1, 2, 5, 6 and 7 always leave the block with the same value they entered with.
- R4: In in-loop mode (`post_mode`=0), P0 and Q0 are passed through unchanged unless all of these hold: `bs` is nonzero, |P0-Q0| < `alpha`, |P1-P0| < `beta`, and |Q1-Q0| < `beta`.
- R5: When an in-loop line is filtered, the correction is floor((4*(Q0-P0) + (P1-Q1) + 4) / 8), clamped to [-`tc`, +`tc`].
- R6: A filtered line outputs P0+d and Q0-d, where d is the clamped correction. Each result is saturated to 0..255.
- R7: When a post-loop line (`post_mode`=1) is filtered, the correction is floor((2*(Q0-P0) + (P1-Q1) + 2) / 4), clamped to [-`qscale`, +`qscale`].
- R8: In post-loop mode, `bs` and `tc` have no effect. The line is filtered exactly when |P0-Q0| < `alpha`, |P1-P0| < `beta` and |Q1-Q0| < `beta`.
- R9: Lines may arrive on consecutive cycles with a different mode and different controls on each line, and every line is processed with its own controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input line is valid this cycle |
| post_mode | input | 1 | 1 = post-loop behaviour, 0 = in-loop behaviour |
| bs | input | 3 | Boundary strength; zero disables in-loop filtering |
| alpha | input | 8 | Threshold on the step across the edge |
| beta | input | 8 | Threshold on the activity on each side |
| tc | input | 8 | In-loop clip bound |
| qscale | input | 5 | Post-loop clip bound |
| pix_in | input | 64 | Eight packed input pixels |
| out_vld | output | 1 | Output line is valid |
| pix_out | output | 64 | Eight packed output pixels |

## Verification
The bench targets the saturation corners, where P0 is pushed above 255 and Q0 is pushed below 0. A design that wraps instead of saturating would show values near the opposite end of the range there. It also drives threshold values exactly equal to each difference. Using a non-strict compare would then filter lines that must pass, and zero `bs` in in-loop mode would do the same if the boundary strength were ignored. Post-loop lines are sent with `bs` and `tc` at zero, so a design that shares the wrong gate or bound would leave them unfiltered. Lines alternate between modes back to back, so a decision taken one line late, or taken from the wrong mode, shows up as a mismatch on the next line.

// File: rtl/esm_pkg.sv
package esm_pkg;
  localparam int PW    = 8;
  localparam int NSIDE = 4;
  localparam int LANES = 2 * NSIDE;
  localparam int DTW   = PW + 4;
  localparam int QW    = 5;
  localparam int BSW   = 3;
  localparam int LP1   = NSIDE - 2;
  localparam int LP0   = NSIDE - 1;
  localparam int LQ0   = NSIDE;
  localparam int LQ1   = NSIDE + 1;

  typedef logic [PW-1:0]         pix_t;
  typedef logic signed [DTW-1:0] dlt_t;
  typedef enum logic {SEL_PASS = 1'b0, SEL_FILT = 1'b1} sel_e;

  function automatic pix_t absd(input pix_t a, input pix_t b);
    return (a > b) ? pix_t'(a - b) : pix_t'(b - a);
  endfunction

  function automatic dlt_t ext(input pix_t a);
    return $signed({{(DTW-PW){1'b0}}, a});
  endfunction

  function automatic dlt_t raw_inloop(input pix_t p1, input pix_t p0,
                                      input pix_t q0, input pix_t q1);
    dlt_t t;
    t = ((ext(q0) - ext(p0)) <<< 2) + (ext(p1) - ext(q1)) + dlt_t'(4);
    return t >>> 3;
  endfunction

  function automatic dlt_t raw_post(input pix_t p1, input pix_t p0,
                                    input pix_t q0, input pix_t q1);
    dlt_t t;
    t = ((ext(q0) - ext(p0)) <<< 1) + (ext(p1) - ext(q1)) + dlt_t'(2);
    return t >>> 2;
  endfunction

  function automatic dlt_t clip3(input dlt_t lo, input dlt_t hi, input dlt_t z);
    if (z < lo) return lo;
    if (z > hi) return hi;
    return z;
  endfunction

  function automatic pix_t sat(input dlt_t v);
    if (v < dlt_t'(0)) return '0;
    if (v > ext({PW{1'b1}})) return {PW{1'b1}};
    return v[PW-1:0];
  endfunction
endpackage

// File: rtl/esm_decide.sv
module esm_decide import esm_pkg::*; (
  input  logic           post_mode,
  input  logic [BSW-1:0] bs,
  input  pix_t           alpha,
  input  pix_t           beta,
  input  pix_t           p1,
  input  pix_t           p0,
  input  pix_t           q0,
  input  pix_t           q1,
  output sel_e           sel
);
  logic strength_ok;
  logic step_ok;
  logic side_ok;

  assign strength_ok = post_mode || (bs != '0);
  assign step_ok     = absd(p0, q0) < alpha;
  assign side_ok     = (absd(p1, p0) < beta) && (absd(q1, q0) < beta);
  assign sel         = (strength_ok && step_ok && side_ok) ? SEL_FILT : SEL_PASS;
endmodule

// File: rtl/esm_delta.sv
module esm_delta import esm_pkg::*; (
  input  logic          post_mode,
  input  pix_t          p1,
  input  pix_t          p0,
  input  pix_t          q0,
  input  pix_t          q1,
  input  pix_t          tc,
  input  logic [QW-1:0] qscale,
  output dlt_t          delta,
  output dlt_t          bound
);
  dlt_t raw;

  always_comb begin
    if (post_mode) begin
      raw   = raw_post(p1, p0, q0, q1);
      bound = $signed({{(DTW-QW){1'b0}}, qscale});
    end else begin
      raw   = raw_inloop(p1, p0, q0, q1);
      bound = ext(tc);
    end
    delta = clip3(-bound, bound, raw);
  end
endmodule

// File: rtl/esm_apply.sv
module esm_apply import esm_pkg::*; (
  input  sel_e sel,
  input  dlt_t delta,
  input  pix_t p0,
  input  pix_t q0,
  output pix_t p0_new,
  output pix_t q0_new
);
  pix_t p0_f;
  pix_t q0_f;

  assign p0_f   = sat(ext(p0) + delta);
  assign q0_f   = sat(ext(q0) - delta);
  assign p0_new = (sel == SEL_FILT) ? p0_f : p0;
  assign q0_new = (sel == SEL_FILT) ? q0_f : q0;
endmodule

// File: rtl/edge_smoother.sv
module edge_smoother import esm_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic                post_mode,
  input  logic [BSW-1:0]      bs,
  input  logic [PW-1:0]       alpha,
  input  logic [PW-1:0]       beta,
  input  logic [PW-1:0]       tc,
  input  logic [QW-1:0]       qscale,
  input  logic [LANES*PW-1:0] pix_in,
  output logic                out_vld,
  output logic [LANES*PW-1:0] pix_out
);
  pix_t in_lane [LANES];
  pix_t s1_pix  [LANES];
  pix_t o_pix   [LANES];
  sel_e dec_sel;
  dlt_t dec_delta;
  dlt_t dec_bound;
  logic s1_vld;
  sel_e s1_sel;
  dlt_t s1_delta;
  dlt_t s1_bound;
  pix_t p0_new;
  pix_t q0_new;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign in_lane[g]          = pix_in[g*PW +: PW];
    assign pix_out[g*PW +: PW] = o_pix[g];
  end

  esm_decide u_decide (
    .post_mode(post_mode), .bs(bs), .alpha(alpha), .beta(beta),
    .p1(in_lane[LP1]), .p0(in_lane[LP0]), .q0(in_lane[LQ0]), .q1(in_lane[LQ1]),
    .sel(dec_sel)
  );

  esm_delta u_delta (
    .post_mode(post_mode),
    .p1(in_lane[LP1]), .p0(in_lane[LP0]), .q0(in_lane[LQ0]), .q1(in_lane[LQ1]),
    .tc(tc), .qscale(qscale), .delta(dec_delta), .bound(dec_bound)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_sel   <= SEL_PASS;
      s1_delta <= '0;
      s1_bound <= '0;
      for (int i = 0; i < LANES; i++) s1_pix[i] <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_sel   <= dec_sel;
        s1_delta <= dec_delta;
        s1_bound <= dec_bound;
        for (int i = 0; i < LANES; i++) s1_pix[i] <= in_lane[i];
      end
    end
  end

  esm_apply u_apply (
    .sel(s1_sel), .delta(s1_delta), .p0(s1_pix[LP0]), .q0(s1_pix[LQ0]),
    .p0_new(p0_new), .q0_new(q0_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      for (int i = 0; i < LANES; i++) o_pix[i] <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        for (int i = 0; i < LANES; i++) begin
          if (i == LP0)      o_pix[i] <= p0_new;
          else if (i == LQ0) o_pix[i] <= q0_new;
          else               o_pix[i] <= s1_pix[i];
        end
      end
    end
  end
endmodule

// File: rtl/esm_chk.sv
module esm_chk import esm_pkg::*; (
  input logic                clk,
  input logic                rst_n,
  input logic                in_vld,
  input logic                post_mode,
  input logic [BSW-1:0]      bs,
  input logic [LANES*PW-1:0] pix_in,
  input logic                out_vld,
  input logic [LANES*PW-1:0] pix_out,
  input logic                s1_sel,
  input logic [DTW-1:0]      s1_delta,
  input logic [DTW-1:0]      s1_bound
);
  logic [1:0] cyc;
  logic       warm;
  localparam int OUTER_LO = LP0 * PW;
  localparam int OUTER_HI = (LQ1) * PW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end
  assign warm = (cyc == 2'd2);

  AST_VLD_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_vld == $past(in_vld, 2))); // R1

  AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_vld) |->
      (pix_out[OUTER_LO-1:0] == $past(pix_in[OUTER_LO-1:0], 2)) &&
      (pix_out[LANES*PW-1:OUTER_HI] == $past(pix_in[LANES*PW-1:OUTER_HI], 2))); // R3

  AST_BS0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_vld && !post_mode && (bs == '0), 2)) |->
      (pix_out == $past(pix_in, 2))); // R4

  AST_DELTA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    s1_sel |-> (($signed(s1_delta) <= $signed(s1_bound)) &&
                ($signed(s1_delta) >= -$signed(s1_bound)))); // R5
endmodule

bind edge_smoother esm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .post_mode(post_mode), .bs(bs),
  .pix_in(pix_in), .out_vld(out_vld), .pix_out(pix_out),
  .s1_sel(s1_sel), .s1_delta(s1_delta), .s1_bound(s1_bound)
);

// File: tb/sim_edge_smoother.sv
module sim_edge_smoother;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        post_mode = 1'b0;
  logic [2:0]  bs = '0;
  logic [7:0]  alpha = '0, beta = '0, tc = '0;
  logic [4:0]  qscale = '0;
  logic [63:0] pix_in = '0;
  logic        out_vld;
  logic [63:0] pix_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] exp1 = '0, exp2 = '0;
  logic        v1 = 1'b0, v2 = 1'b0;
  string       tag1 = "", tag2 = "", cur_tag = "";
  logic [63:0] cur_exp = '0;

  edge_smoother u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .post_mode(post_mode), .bs(bs),
    .alpha(alpha), .beta(beta), .tc(tc), .qscale(qscale), .pix_in(pix_in),
    .out_vld(out_vld), .pix_out(pix_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int fdiv(int n, int d);
    if (n >= 0) return n / d;
    return -((-n + d - 1) / d);
  endfunction

  function automatic int lim(int lo, int hi, int z);
    return (z < lo) ? lo : ((z > hi) ? hi : z);
  endfunction

  // reference: lane k = bits [8k+7:8k]; p1=lane2 p0=lane3 q0=lane4 q1=lane5
  function automatic logic [63:0] ref_line(bit post, int b, int al, int be,
                                           int t, int qs, logic [63:0] px);
    int p1, p0, q0, q1, d, bnd;
    bit go;
    logic [63:0] r;
    p1 = px[23:16]; p0 = px[31:24]; q0 = px[39:32]; q1 = px[47:40];
    go = (post || b != 0) && iabs(p0 - q0) < al &&
         iabs(p1 - p0) < be && iabs(q1 - q0) < be;
    r = px;
    if (go) begin
      if (post) begin d = fdiv(2*(q0 - p0) + (p1 - q1) + 2, 4); bnd = qs; end
      else      begin d = fdiv(4*(q0 - p0) + (p1 - q1) + 4, 8); bnd = t;  end
      d = lim(-bnd, bnd, d);
      r[31:24] = 8'(lim(0, 255, p0 + d));
      r[39:32] = 8'(lim(0, 255, q0 - d));
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      v1 = 1'b0; v2 = 1'b0;
    end else begin
      exp2 = exp1; v2 = v1; tag2 = tag1;
      exp1 = cur_exp; v1 = in_vld; tag1 = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (v2 || out_vld)) begin
      n_chk++;
      if (out_vld !== v2 || (v2 && pix_out !== exp2)) begin
        n_bad++;
        $display("FAIL %s: vld=%0b pix=%h expected vld=%0b pix=%h",
                 tag2, out_vld, pix_out, v2, exp2);
      end
    end
  end

  task automatic send(string tg, bit post, int b, int al, int be, int t, int qs,
                      logic [63:0] px);
    @(negedge clk);
    in_vld = 1'b1; post_mode = post; bs = 3'(b); alpha = 8'(al); beta = 8'(be);
    tc = 8'(t); qscale = 5'(qs); pix_in = px; cur_tag = tg;
    cur_exp = ref_line(post, b, al, be, t, qs, px);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0; cur_tag = "R1";
      pix_in = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  function automatic logic [63:0] mk(int a0, int a1, int a2, int a3,
                                     int b0, int b1, int b2, int b3);
    return {8'(b3), 8'(b2), 8'(b1), 8'(b0), 8'(a3), 8'(a2), 8'(a1), 8'(a0)};
  endfunction

  int seed = 12345;
  function automatic int rnd(int m);
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >>> 8) % m;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_vld !== 1'b0 || pix_out !== '0) begin
      n_bad++;
      $display("FAIL R2: vld=%0b pix=%h expected vld=0 pix=0", out_vld, pix_out);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // R1: single line then idle, latency visible in vld sequence
    send("R1", 0, 2, 40, 20, 3, 0, mk(10, 20, 30, 40, 50, 60, 70, 80));
    idle(3);
    // R5 in-loop delta clipped by tc
    send("R5", 0, 1, 40, 20, 2, 0, mk(1, 2, 30, 36, 60, 55, 9, 8));
    send("R5", 0, 1, 40, 20, 9, 0, mk(1, 2, 30, 36, 60, 55, 9, 8));
    send("R5", 0, 4, 40, 20, 9, 0, mk(0, 0, 60, 58, 40, 45, 0, 0));
    // R4 gating: bs zero, thresholds exactly equal
    send("R4", 0, 0, 40, 20, 9, 0, mk(1, 2, 30, 36, 60, 55, 9, 8));
    send("R4", 0, 1, 24, 20, 9, 0, mk(1, 2, 30, 36, 60, 55, 9, 8));
    send("R4", 0, 1, 40, 6,  9, 0, mk(1, 2, 30, 36, 60, 55, 9, 8));
    send("R4", 0, 1, 40, 5,  9, 0, mk(1, 2, 36, 36, 60, 55, 9, 8));
    // R6 saturation
    send("R6", 0, 1, 255, 255, 20, 0, mk(7, 7, 253, 253, 255, 200, 7, 7));
    send("R6", 0, 1, 255, 255, 20, 0, mk(7, 7, 50, 2, 0, 0, 7, 7));
    // R3 outer lanes with extreme values
    send("R3", 0, 3, 255, 255, 255, 0, mk(255, 0, 128, 120, 130, 125, 0, 255));
    // R7 post-loop delta
    send("R7", 1, 1, 60, 30, 0, 4,  mk(5, 6, 40, 44, 70, 66, 5, 6));
    send("R7", 1, 1, 60, 30, 0, 31, mk(5, 6, 40, 44, 70, 66, 5, 6));
    send("R7", 1, 1, 60, 30, 0, 31, mk(5, 6, 70, 66, 40, 44, 5, 6));
    // R8 post-loop ignores bs and tc
    send("R8", 1, 0, 60, 30, 0, 6,   mk(5, 6, 40, 44, 70, 66, 5, 6));
    send("R8", 1, 7, 60, 30, 255, 1, mk(5, 6, 40, 44, 70, 66, 5, 6));
    send("R8", 1, 0, 26, 30, 0, 6,   mk(5, 6, 40, 44, 70, 66, 5, 6));
    // R9 back-to-back lines, alternating modes, random controls
    for (int k = 0; k < 400; k++) begin
      int base = rnd(256);
      logic [63:0] px;
      for (int j = 0; j < 8; j++)
        px[j*8 +: 8] = 8'(lim(0, 255, base + rnd(41) - 20 + ((j >= 4) ? rnd(31) - 15 : 0)));
      send("R9", k[0], rnd(5), rnd(256), rnd(40), rnd(30), rnd(32), px);
      if (rnd(8) == 0) idle(1);
    end
    idle(4);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule